// File: doc/BRIEF.md
# Banked Data RAM Window Controller

This block holds the 1 KB data memory of an 8052-style core and resolves every access onto one shared byte array. The core reaches the 256 internal bytes through a direct/indirect address bus (a mode flag picks the addressing kind). The 768 expanded bytes sit behind a separate external-space (MOVX-style) port. Because the two ports feed the same array, the same byte always reads the same value, whichever path wrote it.

A bank-select register on the SFR write port turns direct addresses 40h–7Fh into a 64-byte window. The window can then reach any of sixteen banks covering the whole 1 KB. Banks 0–3 land on the internal bytes and banks 4–15 land on the expanded bytes. This lets code that only uses direct addressing read and write all of the memory. Reads are synchronous, and their data appears one clock after the strobe.

Top module: `banked_ram_ctrl`

## Requirements
- R1: Reset clears the bank-select register to 00h, which disables the window. The SFR read data at the register's address (86h) is 00h after reset.
- R2: An SFR write to address 86h loads the register on that clock edge. Bit 7 is the window enable, bits 3:0 are the bank number, and bits 6:4 always read 0. SFR writes to any other address leave the register unchanged, and SFR reads of any other address return 00h.
- R3: With the window disabled, or for a direct address below 40h, a direct access to 00h–7Fh reaches the internal byte at that same address. Read data appears on `int_rdata` one cycle after `int_rd`. At most one of the four access strobes is high in a cycle.
- R4: An indirect access (mode flag 1) to 00h–FFh reaches the internal byte at that address and is never remapped. A direct access (mode flag 0) to 80h–FFh belongs to SFR space: it writes no RAM byte, and its read returns 00h.
- R5: With the window enabled and bank number b from 0 to 3, a direct access to 40h+k (k from 0 to 3Fh) reaches internal byte b×64+k.
- R6: With the window enabled and bank number b from 4 to 15, a direct access to 40h+k reaches expanded byte (b−4)×64+k. For example, bank 8 with address 41h reaches external address 0101h.
- R7: A MOVX access to 0000h–02FFh reaches the expanded byte at that address. Read data appears on `x_rdata` one cycle after `x_rd`.
- R8: A MOVX write above 02FFh changes no byte. A MOVX read above 02FFh returns FFh.
- R9: A window access in the cycle right after a bank-register write uses the newly written bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_addr | input | 8 | Internal (direct/indirect) address |
| int_indirect | input | 1 | 1 = indirect access, 0 = direct access |
| int_rd | input | 1 | Internal read strobe |
| int_wr | input | 1 | Internal write strobe |
| int_wdata | input | 8 | Internal write data |
| int_rdata | output | 8 | Internal read data, valid one cycle after int_rd |
| x_addr | input | 16 | External-space (MOVX) address |
| x_rd | input | 1 | External-space read strobe |
| x_wr | input | 1 | External-space write strobe |
| x_wdata | input | 8 | External-space write data |
| x_rdata | output | 8 | External-space read data, valid one cycle after x_rd |
| sfr_addr | input | 8 | SFR address |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | Bank register readback when sfr_addr is 86h, else 00h |

## Verification
The assertions assume that the core issues at most one RAM access per cycle. That means a single strobe from int_rd, int_wr, x_rd and x_wr, never a read and a write together and never both ports at once. The bench keeps to this because each stimulus task raises exactly one strobe for one cycle and lowers it before the next task starts. The only overlap is an SFR write followed at once by a window access, which is the case R9 covers. The assertions also take the read data as meaningful only in the cycle after a read strobe, and the bench samples it only there.

// File: rtl/bankram_pkg.sv
package bankram_pkg;

   // Tag recorded with each read so the output mux knows what to return
   typedef enum logic [1:0] {
      RK_RAM   = 2'd0,
      RK_BLANK = 2'd1,
      RK_OOR   = 2'd2
   } rd_kind_e;

endpackage

// File: rtl/bank_select_reg.sv
module bank_select_reg #(
   parameter int              DATA_W   = 8,
   parameter int              SADDR_W  = 8,
   parameter int              BS_W     = 4,
   parameter int              EN_BIT   = 7,
   parameter logic [SADDR_W-1:0] REG_ADDR = 8'h86
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SADDR_W-1:0] sfr_addr,
   input  logic               sfr_wr,
   input  logic [DATA_W-1:0]  sfr_wdata,
   output logic [DATA_W-1:0]  sfr_rdata,
   output logic               bank_en,
   output logic [BS_W-1:0]    bank_sel
);

   localparam logic [DATA_W-1:0] KEEP_MASK =
      DATA_W'((1 << BS_W) - 1) | (DATA_W'(1) << EN_BIT);

   if (EN_BIT < BS_W || EN_BIT >= DATA_W) begin : g_bad_en
      $error("bank_select_reg: enable bit must sit above the bank field");
   end

   logic              hit;
   logic              load;
   logic [DATA_W-1:0] bank_q;

   assign hit  = (sfr_addr == REG_ADDR);
   assign load = sfr_wr && hit;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (i < BS_W || i == EN_BIT) begin : g_keep
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    bank_q[i] <= 1'b0;
            else if (load) bank_q[i] <= sfr_wdata[i];
         end
      end else begin : g_rsvd
         assign bank_q[i] = 1'b0;
      end
   end

   assign sfr_rdata = hit ? bank_q : '0;
   assign bank_en   = bank_q[EN_BIT];
   assign bank_sel  = bank_q[BS_W-1:0];

   assert_reset_clear_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> (bank_q == '0));

   assert_bank_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (bank_q == ($past(sfr_wdata) & KEEP_MASK)));

   assert_bank_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(bank_q));

endmodule

// File: rtl/addr_resolve.sv
module addr_resolve
   import bankram_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int IADDR_W    = 8,
   parameter int XADDR_W    = 16,
   parameter int PHYS_W     = 10,
   parameter int BS_W       = 4,
   parameter int OFS_W      = 6,
   parameter int INT_BYTES  = 256,
   parameter int EXT_BYTES  = 768,
   parameter int DIRECT_LIM = 128,
   parameter int WIN_BASE   = 64
) (
   input  logic [IADDR_W-1:0] int_addr,
   input  logic               int_indirect,
   input  logic               int_rd,
   input  logic               int_wr,
   input  logic [DATA_W-1:0]  int_wdata,
   input  logic [XADDR_W-1:0] x_addr,
   input  logic               x_rd,
   input  logic               x_wr,
   input  logic [DATA_W-1:0]  x_wdata,
   input  logic               bank_en,
   input  logic [BS_W-1:0]    bank_sel,
   output logic [PHYS_W-1:0]  mem_addr,
   output logic               mem_we,
   output logic               mem_re,
   output logic [DATA_W-1:0]  mem_wdata,
   output rd_kind_e           rd_kind
);

   localparam logic [IADDR_W-1:0] DIR_LIM_A = IADDR_W'(DIRECT_LIM);
   localparam logic [IADDR_W-1:0] WIN_LO_A  = IADDR_W'(WIN_BASE);
   localparam logic [XADDR_W-1:0] EXT_LIM_A = XADDR_W'(EXT_BYTES);
   localparam logic [PHYS_W-1:0]  EXT_BASE  = PHYS_W'(INT_BYTES);

   if (BS_W + OFS_W != PHYS_W) begin : g_bad_split
      $error("addr_resolve: bank and offset fields must fill the physical address");
   end
   if (WIN_BASE % (1 << OFS_W) != 0) begin : g_bad_win
      $error("addr_resolve: window base must be bank aligned");
   end
   if (XADDR_W < PHYS_W || IADDR_W > PHYS_W) begin : g_bad_aw
      $error("addr_resolve: address widths inconsistent");
   end

   logic int_act, x_act, dir_sfr, in_win, x_in;

   assign int_act = int_rd | int_wr;
   assign x_act   = x_rd | x_wr;
   assign dir_sfr = !int_indirect && (int_addr >= DIR_LIM_A);
   assign in_win  = !int_indirect && bank_en &&
                    (int_addr[IADDR_W-1:OFS_W] == WIN_LO_A[IADDR_W-1:OFS_W]);
   assign x_in    = (x_addr < EXT_LIM_A);

   always_comb begin
      mem_addr  = '0;
      mem_we    = 1'b0;
      mem_re    = 1'b0;
      mem_wdata = int_wdata;
      rd_kind   = RK_RAM;
      if (int_act) begin
         if (dir_sfr) begin
            rd_kind = RK_BLANK;
         end else begin
            mem_we   = int_wr;
            mem_re   = int_rd;
            mem_addr = in_win ? {bank_sel, int_addr[OFS_W-1:0]} : PHYS_W'(int_addr);
         end
      end else if (x_act) begin
         mem_wdata = x_wdata;
         if (x_in) begin
            mem_we   = x_wr;
            mem_re   = x_rd;
            mem_addr = x_addr[PHYS_W-1:0] + EXT_BASE;
         end else begin
            rd_kind = RK_OOR;
         end
      end
   end

endmodule

// File: rtl/ram_sp.sv
module ram_sp #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 1024,
   parameter int AW     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic              re,
   input  logic [AW-1:0]     addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   if ((1 << AW) < DEPTH) begin : g_bad_aw
      $error("ram_sp: address too narrow for depth");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
      if (re) rdata     <= mem[addr];
   end

endmodule

// File: rtl/banked_ram_ctrl.sv
module banked_ram_ctrl
   import bankram_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int IADDR_W    = 8,
   parameter int XADDR_W    = 16,
   parameter int SADDR_W    = 8,
   parameter int INT_BYTES  = 256,
   parameter int EXT_BYTES  = 768,
   parameter int BANK_BYTES = 64,
   parameter int DIRECT_LIM = 128,
   parameter int WIN_BASE   = 64,
   parameter int EN_BIT     = 7,
   parameter logic [SADDR_W-1:0] BANK_REG_ADDR = 8'h86
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [IADDR_W-1:0] int_addr,
   input  logic               int_indirect,
   input  logic               int_rd,
   input  logic               int_wr,
   input  logic [DATA_W-1:0]  int_wdata,
   output logic [DATA_W-1:0]  int_rdata,
   input  logic [XADDR_W-1:0] x_addr,
   input  logic               x_rd,
   input  logic               x_wr,
   input  logic [DATA_W-1:0]  x_wdata,
   output logic [DATA_W-1:0]  x_rdata,
   input  logic [SADDR_W-1:0] sfr_addr,
   input  logic               sfr_wr,
   input  logic [DATA_W-1:0]  sfr_wdata,
   output logic [DATA_W-1:0]  sfr_rdata
);

   localparam int TOTAL     = INT_BYTES + EXT_BYTES;
   localparam int PHYS_W    = $clog2(TOTAL);
   localparam int OFS_W     = $clog2(BANK_BYTES);
   localparam int BANKS     = TOTAL / BANK_BYTES;
   localparam int BS_W      = $clog2(BANKS);
   localparam int INT_BANKS = INT_BYTES / BANK_BYTES;
   localparam logic [BS_W-1:0]    INT_BANKS_S = BS_W'(INT_BANKS);
   localparam logic [PHYS_W-1:0]  INT_TOP     = PHYS_W'(INT_BYTES);
   localparam logic [XADDR_W-1:0] EXT_LIM_A   = XADDR_W'(EXT_BYTES);
   localparam logic [IADDR_W-1:0] DIR_LIM_A   = IADDR_W'(DIRECT_LIM);
   localparam logic [IADDR_W-1:0] WIN_LO_A    = IADDR_W'(WIN_BASE);
   localparam logic [IADDR_W-1:0] WIN_HI_A    = IADDR_W'(WIN_BASE + BANK_BYTES);

   if (TOTAL != (1 << PHYS_W) || BANKS * BANK_BYTES != TOTAL) begin : g_bad_total
      $error("banked_ram_ctrl: total size must be a power of two split into whole banks");
   end
   if (INT_BYTES % BANK_BYTES != 0 || INT_BYTES != (1 << IADDR_W)) begin : g_bad_int
      $error("banked_ram_ctrl: internal space must be whole banks and fill the address");
   end
   if (WIN_BASE + BANK_BYTES > DIRECT_LIM) begin : g_bad_win
      $error("banked_ram_ctrl: window must sit inside the direct RAM range");
   end

   logic              bank_en;
   logic [BS_W-1:0]   bank_sel;
   logic [PHYS_W-1:0] mem_addr;
   logic              mem_we, mem_re;
   logic [DATA_W-1:0] mem_wdata, mem_q;
   rd_kind_e          rd_kind, kind_q;

   bank_select_reg #(
      .DATA_W(DATA_W), .SADDR_W(SADDR_W), .BS_W(BS_W),
      .EN_BIT(EN_BIT), .REG_ADDR(BANK_REG_ADDR)
   ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata),
      .sfr_rdata(sfr_rdata), .bank_en(bank_en), .bank_sel(bank_sel)
   );

   addr_resolve #(
      .DATA_W(DATA_W), .IADDR_W(IADDR_W), .XADDR_W(XADDR_W), .PHYS_W(PHYS_W),
      .BS_W(BS_W), .OFS_W(OFS_W), .INT_BYTES(INT_BYTES), .EXT_BYTES(EXT_BYTES),
      .DIRECT_LIM(DIRECT_LIM), .WIN_BASE(WIN_BASE)
   ) u_resolve (
      .int_addr(int_addr), .int_indirect(int_indirect),
      .int_rd(int_rd), .int_wr(int_wr), .int_wdata(int_wdata),
      .x_addr(x_addr), .x_rd(x_rd), .x_wr(x_wr), .x_wdata(x_wdata),
      .bank_en(bank_en), .bank_sel(bank_sel),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
      .mem_wdata(mem_wdata), .rd_kind(rd_kind)
   );

   ram_sp #(.DATA_W(DATA_W), .DEPTH(TOTAL), .AW(PHYS_W)) u_ram (
      .clk(clk), .we(mem_we), .re(mem_re), .addr(mem_addr),
      .wdata(mem_wdata), .rdata(mem_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             kind_q <= RK_RAM;
      else if (int_rd | x_rd) kind_q <= rd_kind;
   end

   assign int_rdata = (kind_q == RK_BLANK) ? '0 : mem_q;
   assign x_rdata   = (kind_q == RK_OOR)   ? '1 : mem_q;

   // Input contract: one RAM access per cycle
   assert_one_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({int_rd, int_wr, x_rd, x_wr}) <= 1);

   assert_indirect_flat_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (int_indirect && (int_rd || int_wr)) |-> (mem_addr == PHYS_W'(int_addr)));

   assert_sfr_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (int_wr && !int_indirect && int_addr >= DIR_LIM_A) |-> !mem_we);

   assert_sfr_blank_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (int_rd && !int_indirect && int_addr >= DIR_LIM_A) |=> (int_rdata == '0));

   assert_window_region_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((int_rd || int_wr) && !int_indirect && bank_en &&
       int_addr >= WIN_LO_A && int_addr < WIN_HI_A)
      |-> ((mem_addr >= INT_TOP) == (bank_sel >= INT_BANKS_S)));

   assert_ext_region_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((x_rd || x_wr) && x_addr < EXT_LIM_A) |-> (mem_addr >= INT_TOP));

   assert_oor_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (x_wr && x_addr >= EXT_LIM_A) |-> !mem_we);

   assert_oor_read_ff_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (x_rd && x_addr >= EXT_LIM_A) |=> (x_rdata == '1));

endmodule

// File: tb/tb_banked_ram_ctrl.sv
module tb_banked_ram_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  int_addr = '0;
   logic        int_indirect = 1'b0, int_rd = 1'b0, int_wr = 1'b0;
   logic [7:0]  int_wdata = '0, int_rdata;
   logic [15:0] x_addr = '0;
   logic        x_rd = 1'b0, x_wr = 1'b0;
   logic [7:0]  x_wdata = '0, x_rdata;
   logic [7:0]  sfr_addr = '0, sfr_wdata = '0, sfr_rdata;
   logic        sfr_wr = 1'b0;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   banked_ram_ctrl dut (
      .clk(clk), .rst_n(rst_n),
      .int_addr(int_addr), .int_indirect(int_indirect),
      .int_rd(int_rd), .int_wr(int_wr), .int_wdata(int_wdata), .int_rdata(int_rdata),
      .x_addr(x_addr), .x_rd(x_rd), .x_wr(x_wr), .x_wdata(x_wdata), .x_rdata(x_rdata),
      .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
   );

   task automatic chk(input string req, input string what,
                      input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
      end
   endtask

   task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
      @(negedge clk);
      sfr_wr = 1'b0;
   endtask

   task automatic sfr_read(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      sfr_addr = a;
      #1 d = sfr_rdata;
   endtask

   task automatic iwrite(input logic ind, input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      int_indirect = ind; int_addr = a; int_wdata = d; int_wr = 1'b1;
      @(negedge clk);
      int_wr = 1'b0;
   endtask

   task automatic iread(input logic ind, input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      int_indirect = ind; int_addr = a; int_rd = 1'b1;
      @(negedge clk);
      int_rd = 1'b0;
      d = int_rdata;
   endtask

   task automatic xwrite(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      x_addr = a; x_wdata = d; x_wr = 1'b1;
      @(negedge clk);
      x_wr = 1'b0;
   endtask

   task automatic xread(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      x_addr = a; x_rd = 1'b1;
      @(negedge clk);
      x_rd = 1'b0;
      d = x_rdata;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      sfr_read(8'h86, v);
      chk("R1", "bank register after reset", v, 8'h00);
      iwrite(1'b0, 8'h45, 8'h6B);
      iread(1'b1, 8'h45, v);
      chk("R1", "window off after reset, direct 45h", v, 8'h6B);
   endtask

   task automatic t_bank_reg();
      logic [7:0] v;
      sfr_write(8'h86, 8'hFF);
      sfr_read(8'h86, v);
      chk("R2", "reserved bits read zero", v, 8'h8F);
      sfr_write(8'h87, 8'h00);
      sfr_read(8'h86, v);
      chk("R2", "write to other SFR ignored", v, 8'h8F);
      sfr_read(8'h87, v);
      chk("R2", "other SFR reads zero", v, 8'h00);
      sfr_write(8'h86, 8'h00);
   endtask

   task automatic t_direct_low();
      logic [7:0] v;
      iwrite(1'b0, 8'h10, 8'h21);
      iwrite(1'b0, 8'h7F, 8'hC4);
      iread(1'b0, 8'h10, v);
      chk("R3", "direct 10h", v, 8'h21);
      iread(1'b1, 8'h7F, v);
      chk("R3", "direct write 7Fh seen indirect", v, 8'hC4);
   endtask

   task automatic t_upper();
      logic [7:0] v;
      iwrite(1'b1, 8'h90, 8'hA5);
      iread(1'b1, 8'h90, v);
      chk("R4", "indirect 90h", v, 8'hA5);
      iread(1'b0, 8'h90, v);
      chk("R4", "direct 90h reads zero", v, 8'h00);
      iwrite(1'b0, 8'h90, 8'h3E);
      iread(1'b1, 8'h90, v);
      chk("R4", "direct 90h write left RAM alone", v, 8'hA5);
   endtask

   task automatic t_window_internal();
      logic [7:0] v;
      iwrite(1'b1, 8'h41, 8'h11);
      iwrite(1'b0, 8'h00, 8'h77);
      sfr_write(8'h86, 8'h82);
      iwrite(1'b0, 8'h41, 8'h3C);
      iread(1'b1, 8'h81, v);
      chk("R5", "bank 2 window 41h -> 81h", v, 8'h3C);
      iread(1'b1, 8'h41, v);
      chk("R5", "indirect 41h not remapped", v, 8'h11);
      sfr_write(8'h86, 8'h80);
      iread(1'b0, 8'h40, v);
      chk("R5", "bank 0 window 40h -> 00h", v, 8'h77);
   endtask

   task automatic t_window_expanded();
      logic [7:0] v;
      sfr_write(8'h86, 8'h88);
      iwrite(1'b0, 8'h41, 8'h30);
      xread(16'h0101, v);
      chk("R6", "bank 8 window 41h -> ext 0101h", v, 8'h30);
      sfr_write(8'h86, 8'h8F);
      iwrite(1'b0, 8'h7F, 8'hE1);
      xread(16'h02FF, v);
      chk("R6", "bank 15 window 7Fh -> ext 02FFh", v, 8'hE1);
      sfr_write(8'h86, 8'h08);
      iwrite(1'b0, 8'h41, 8'h99);
      iread(1'b1, 8'h41, v);
      chk("R6", "enable clear, direct 41h internal", v, 8'h99);
      xread(16'h0101, v);
      chk("R6", "enable clear, ext 0101h untouched", v, 8'h30);
   endtask

   task automatic t_movx();
      logic [7:0] v;
      xwrite(16'h0000, 8'h5A);
      xread(16'h0000, v);
      chk("R7", "ext 0000h", v, 8'h5A);
      sfr_write(8'h86, 8'h84);
      iread(1'b0, 8'h40, v);
      chk("R7", "bank 4 window sees ext 0000h", v, 8'h5A);
      iwrite(1'b0, 8'h7E, 8'hB2);
      xread(16'h003E, v);
      chk("R7", "ext 003Eh written by window", v, 8'hB2);
   endtask

   task automatic t_out_of_range();
      logic [7:0] v;
      xwrite(16'h0300, 8'h12);
      xread(16'h0300, v);
      chk("R8", "ext 0300h reads FF", v, 8'hFF);
      xwrite(16'hFFFF, 8'h34);
      xread(16'hFFFF, v);
      chk("R8", "ext FFFFh reads FF", v, 8'hFF);
      xread(16'h0000, v);
      chk("R8", "ext 0000h not aliased", v, 8'h5A);
      xread(16'h02FF, v);
      chk("R8", "ext 02FFh not disturbed", v, 8'hE1);
   endtask

   task automatic t_back_to_back();
      logic [7:0] v;
      sfr_write(8'h86, 8'h80);
      @(negedge clk);
      sfr_addr = 8'h86; sfr_wdata = 8'h8A; sfr_wr = 1'b1;
      @(negedge clk);
      sfr_wr = 1'b0;
      int_indirect = 1'b0; int_addr = 8'h45; int_wdata = 8'hD7; int_wr = 1'b1;
      @(negedge clk);
      int_wr = 1'b0;
      xread(16'h0185, v);
      chk("R9", "window write right after bank write", v, 8'hD7);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_bank_reg();
      t_direct_low();
      t_upper();
      t_window_internal();
      t_window_expanded();
      t_movx();
      t_out_of_range();
      t_back_to_back();
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

endmodule